// File: doc/BRIEF.md
# UART Banked Register Front End and Baud Tick Generator

This block is the bus-facing side of a 16550-style serial port. It decodes two word offsets of a small register window. A bank-select input, driven from a line-control register kept elsewhere, decides what those offsets mean.

With the bank select low, offset 0x0 is the data port. A write hands the byte to a transmit FIFO through a push handshake. A read takes the oldest byte from a receive FIFO through a pop handshake. With the bank select high, offsets 0x0 and 0x4 become the low and high bytes of a 16-bit clock divisor. Both bytes can be read and written.

The divisor drives a down-counter. The counter emits a one-cycle enable pulse every divisor clock cycles. That pulse is the 16x oversampling clock for the serial shifter, which sits outside this block. The FIFO storage also sits outside, and the transmit FIFO sends each byte least significant bit first once it reaches the head and the shifter is idle.

Top module: `uart_bank_regs`

## Requirements
- R1: With bank select 0, a write to offset 0x0 asserts `tx_push` for that cycle, with `tx_data` equal to `bus_wdata`, when `tx_full` is low.
- R2: A data write while `tx_full` is high is dropped: `tx_push` stays low.
- R3: With bank select 0, a read of offset 0x0 while `rx_empty` is low returns `rx_data` on `bus_rdata` and asserts `rx_pop` for exactly that cycle.
- R4: A data read while `rx_empty` is high returns 0x00 and leaves `rx_pop` low.
- R5: With bank select 1, offset 0x0 reads and writes divisor bits 7:0 and offset 0x4 reads and writes divisor bits 15:8. These accesses never assert `tx_push` or `rx_pop`.
- R6: With bank select 0, writes to offset 0x0 or 0x4 leave both divisor bytes unchanged.
- R7: After reset, the low divisor byte reads 0x01, the high divisor byte reads 0x00, and `baud_tick` is low.
- R8: `baud_tick` is a single-cycle pulse whose period in clock cycles equals the 16-bit divisor. With the reset divisor of 1, it is high every cycle.
- R9: A divisor of 0x0000 gives the same tick period as 0x0001.
- R10: A divisor write takes effect at the next reload. The interval already under way finishes with the old divisor, and the following interval uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 1 | Divisor bank select from the external line-control register |
| bus_addr | input | 3 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| tx_push | output | 1 | Push strobe to the transmit FIFO |
| tx_data | output | 8 | Byte pushed to the transmit FIFO |
| tx_full | input | 1 | Transmit FIFO full |
| rx_pop | output | 1 | Pop strobe to the receive FIFO |
| rx_data | input | 8 | Oldest byte in the receive FIFO |
| rx_empty | input | 1 | Receive FIFO empty |
| baud_tick | output | 1 | One-cycle 16x-baud enable |

## Verification
The bench targets three kinds of error.

- **Offset 0x0 sharing.** Offset 0x0 is shared three ways. A decoder that ignored direction or bank select would push while the divisor is being written, or would let a data write corrupt the low divisor byte. The bench walks both banks and both directions to catch this.
- **FIFO boundaries.** A design that popped an empty receive FIFO, or pushed into a full transmit FIFO, would show a stray strobe in those vectors. The bench drives both cases.
- **Tick period.** The bench measures intervals between ticks for these cases:
  - the reset divisor;
  - a zero divisor, where a missing clamp would give a period of 65536;
  - a large divisor that uses the high byte;
  - a divisor change in mid-interval, where applying the change at once would shorten the interval already under way.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 8;
    localparam int DIV_W    = 2 * DATA_W;

    localparam logic [ADDR_W-1:0] OFS_LOW  = 3'h0;
    localparam logic [ADDR_W-1:0] OFS_HIGH = 3'h4;

    localparam logic [DATA_W-1:0] RST_DIV_LO = 8'h01;
    localparam logic [DATA_W-1:0] RST_DIV_HI = 8'h00;

    typedef logic [DIV_W-1:0] divisor_t;

    // Decoded intent of one bus access
    typedef struct packed {
        logic data_wr;
        logic data_rd;
        logic lo_wr;
        logic hi_wr;
        logic lo_rd;
        logic hi_rd;
    } bank_hit_t;

    // Zero is not a legal division ratio; it acts as one
    function automatic divisor_t effective_div(input divisor_t raw);
        return (raw == '0) ? divisor_t'(1) : raw;
    endfunction

endpackage

// File: rtl/uart_reg_decode.sv
module uart_reg_decode
    import uart_regs_pkg::*;
(
    input  logic              bank_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output bank_hit_t         hit
);
    logic at_low;
    logic at_high;

    always_comb begin
        at_low       = (addr == OFS_LOW);
        at_high      = (addr == OFS_HIGH);
        hit.data_wr  = wr && !bank_sel && at_low;
        hit.data_rd  = rd && !bank_sel && at_low;
        hit.lo_wr    = wr &&  bank_sel && at_low;
        hit.hi_wr    = wr &&  bank_sel && at_high;
        hit.lo_rd    = rd &&  bank_sel && at_low;
        hit.hi_rd    = rd &&  bank_sel && at_high;
    end
endmodule

// File: rtl/uart_div_regs.sv
module uart_div_regs
    import uart_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bank_hit_t         hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] div_lo,
    output logic [DATA_W-1:0] div_hi
);
    always_ff @(posedge clk) begin
        if (rst) begin
            div_lo <= RST_DIV_LO;
            div_hi <= RST_DIV_HI;
        end else begin
            if (hit.lo_wr) div_lo <= wdata;
            if (hit.hi_wr) div_hi <= wdata;
        end
    end
endmodule

// File: rtl/uart_tick_gen.sv
module uart_tick_gen
    import uart_regs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  divisor_t divisor,
    output logic     tick
);
    divisor_t remain;

    // Count down to one, then reload from the divisor as it stands now
    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= divisor_t'(1);
            tick   <= 1'b0;
        end else if (remain == divisor_t'(1)) begin
            remain <= effective_div(divisor);
            tick   <= 1'b1;
        end else begin
            remain <= remain - divisor_t'(1);
            tick   <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
    import uart_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bank_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_full,
    output logic              rx_pop,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_empty,
    output logic              baud_tick
);
    bank_hit_t         hit;
    logic [DATA_W-1:0] div_lo;
    logic [DATA_W-1:0] div_hi;

    uart_reg_decode u_decode (
        .bank_sel (bank_sel),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .hit      (hit)
    );

    uart_div_regs u_div (
        .clk    (clk),
        .rst    (rst),
        .hit    (hit),
        .wdata  (bus_wdata),
        .div_lo (div_lo),
        .div_hi (div_hi)
    );

    uart_tick_gen u_tick (
        .clk     (clk),
        .rst     (rst),
        .divisor ({div_hi, div_lo}),
        .tick    (baud_tick)
    );

    assign tx_data = bus_wdata;
    assign tx_push = hit.data_wr && !tx_full;
    assign rx_pop  = hit.data_rd && !rx_empty;

    always_comb begin
        bus_rdata = '0;
        if (hit.lo_rd)                  bus_rdata = div_lo;
        else if (hit.hi_rd)             bus_rdata = div_hi;
        else if (hit.data_rd && !rx_empty) bus_rdata = rx_data;
    end
endmodule

// File: rtl/uart_bank_regs_checker.sv
module uart_bank_regs_checker
    import uart_regs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bank_sel,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tx_push,
    input logic              tx_full,
    input logic              rx_pop,
    input logic              rx_empty,
    input logic [DATA_W-1:0] div_lo,
    input logic [DATA_W-1:0] div_hi
);
    p_push_source_r1: assert property (@(posedge clk) disable iff (rst)
        tx_push |-> (bus_wr && !bank_sel && bus_addr == OFS_LOW));

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        tx_full |-> !tx_push);

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        rx_empty |-> (!rx_pop && (bus_rdata == '0 || bank_sel)));

    p_bank_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        bank_sel |-> (!tx_push && !rx_pop));

    p_div_held_r6: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bank_sel) |=> $stable({div_hi, div_lo}));
endmodule

bind uart_bank_regs uart_bank_regs_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bank_sel  (bank_sel),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .tx_push   (tx_push),
    .tx_full   (tx_full),
    .rx_pop    (rx_pop),
    .rx_empty  (rx_empty),
    .div_lo    (div_lo),
    .div_hi    (div_hi)
);

// File: tb/uart_bank_regs_tb.sv
module uart_bank_regs_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bank_sel = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tx_push;
    logic [7:0] tx_data;
    logic       tx_full = 1'b0;
    logic       rx_pop;
    logic [7:0] rx_data = '0;
    logic       rx_empty = 1'b1;
    logic       baud_tick;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    uart_bank_regs u_dut (
        .clk(clk), .rst(rst), .bank_sel(bank_sel), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tx_push(tx_push), .tx_data(tx_data),
        .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_empty(rx_empty), .baud_tick(baud_tick)
    );

    typedef struct packed {
        logic       sel;
        logic       wr;
        logic       rd;
        logic [2:0] addr;
        logic [7:0] wdata;
        logic       empty;
        logic       full;
        logic [7:0] rxd;
        logic [7:0] exp_rdata;
        logic       exp_push;
        logic       exp_pop;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b1, 3'h0, 8'h00, 1'b1, 1'b0, 8'h00, 8'h01, 1'b0, 1'b0, 4'd7},  // R7 low
        '{1'b1, 1'b0, 1'b1, 3'h4, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd7},  // R7 high
        '{1'b1, 1'b1, 1'b0, 3'h0, 8'h34, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 write low
        '{1'b1, 1'b1, 1'b0, 3'h4, 8'h12, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 write high
        '{1'b1, 1'b0, 1'b1, 3'h0, 8'h00, 1'b0, 1'b0, 8'h66, 8'h34, 1'b0, 1'b0, 4'd5},  // R5 read low
        '{1'b1, 1'b0, 1'b1, 3'h4, 8'h00, 1'b0, 1'b0, 8'h66, 8'h12, 1'b0, 1'b0, 4'd5},  // R5 read high
        '{1'b0, 1'b1, 1'b0, 3'h0, 8'hA5, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 4'd1},  // R1 push
        '{1'b0, 1'b1, 1'b0, 3'h0, 8'h5A, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 4'd2},  // R2 full drop
        '{1'b0, 1'b0, 1'b1, 3'h0, 8'h00, 1'b0, 1'b0, 8'h3C, 8'h3C, 1'b0, 1'b1, 4'd3},  // R3 pop
        '{1'b0, 1'b0, 1'b1, 3'h0, 8'h00, 1'b1, 1'b0, 8'h77, 8'h00, 1'b0, 1'b0, 4'd4},  // R4 empty
        '{1'b0, 1'b1, 1'b0, 3'h4, 8'h99, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd6},  // R6 write at 0x4
        '{1'b1, 1'b0, 1'b1, 3'h0, 8'h00, 1'b0, 1'b0, 8'hEE, 8'h34, 1'b0, 1'b0, 4'd6},  // R6 low kept
        '{1'b1, 1'b0, 1'b1, 3'h4, 8'h00, 1'b0, 1'b0, 8'hEE, 8'h12, 1'b0, 1'b0, 4'd6}   // R6 high kept
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        bus_wr = 1'b0; bus_rd = 1'b0; bank_sel = 1'b0; bus_addr = '0;
    endtask

    task automatic wr_div(input logic [15:0] d);
        @(negedge clk);
        bank_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'h0; bus_wdata = d[7:0];
        @(negedge clk);
        bus_addr = 3'h4; bus_wdata = d[15:8];
        @(negedge clk);
        idle();
    endtask

    // From a negedge, count negedges until baud_tick is seen high
    task automatic gap(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!baud_tick && n < 70000);
    endtask

    task automatic period_of(input logic [15:0] d, output int n);
        int junk;
        wr_div(d);
        gap(junk);
        gap(junk);
        gap(n);
    endtask

    initial begin
        int p;
        int hi_cnt;
        // Reset state (R7)
        repeat (3) @(negedge clk);
        check("R7 tick low in reset", baud_tick, 1'b0);
        rst = 1'b0;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bank_sel = VECS[i].sel; bus_wr = VECS[i].wr; bus_rd = VECS[i].rd;
            bus_addr = VECS[i].addr; bus_wdata = VECS[i].wdata;
            rx_empty = VECS[i].empty; tx_full = VECS[i].full; rx_data = VECS[i].rxd;
            #1;
            check($sformatf("R%0d vec %0d rdata", VECS[i].req, i), bus_rdata, VECS[i].exp_rdata);
            check($sformatf("R%0d vec %0d push", VECS[i].req, i), tx_push, VECS[i].exp_push);
            check($sformatf("R%0d vec %0d pop", VECS[i].req, i), rx_pop, VECS[i].exp_pop);
            if (VECS[i].exp_push) check("R1 tx_data", tx_data, VECS[i].wdata);
        end
        @(negedge clk);
        idle(); rx_empty = 1'b1; tx_full = 1'b0;

        // Reset again: divisor back to 01/00, tick every cycle (R7, R8)
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        bank_sel = 1'b1; bus_rd = 1'b1; bus_addr = 3'h0; #1;
        check("R7 low after reset", bus_rdata, 8'h01);
        bus_addr = 3'h4; #1;
        check("R7 high after reset", bus_rdata, 8'h00);
        idle();
        hi_cnt = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (baud_tick) hi_cnt++;
        end
        check("R8 divisor 1 ticks every cycle", hi_cnt, 5);

        // R8 period and pulse width
        period_of(16'd3, p);
        check("R8 period 3", p, 3);
        @(negedge clk);
        check("R8 single-cycle pulse", baud_tick, 1'b0);
        period_of(16'h0100, p);
        check("R8 period 0x100", p, 256);

        // R9 zero clamps to one
        period_of(16'h0000, p);
        check("R9 zero divisor period", p, 1);

        // R10 change takes effect at next reload
        period_of(16'd8, p);
        check("R10 old period 8", p, 8);
        @(negedge clk);
        bank_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'h0; bus_wdata = 8'd3;
        @(negedge clk);
        idle();
        p = 2;
        do begin
            @(negedge clk);
            p++;
        end while (!baud_tick && p < 100);
        check("R10 interval in progress keeps 8", p, 8);
        gap(p);
        check("R10 next interval uses 3", p, 3);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule